// File: doc/BRIEF.md
# Prioritised Interrupt Claim Core

This block sits at the centre of a platform interrupt controller with a configurable number of sources and targets. Gateways hand it one-cycle request pulses. Each pulse sets a pending bit for that source, and the bit holds until a target claims the source. Software programs three things through a small write port:

- a priority for each source;
- an enable mask for each target;
- a threshold for each target.

For each target, the core keeps a registered notification line. The line is high whenever that target has something worth taking. Every target is judged on its own, with no interaction between targets.

A target takes an interrupt by issuing a claim. The claim returns the identifier of the best eligible pending source for that target and clears that source's pending bit in the same operation. Identifier 0 means nothing was available. All enabled targets are notified of a source. Only the first claimer is given its identifier. After the handler finishes, a completion carrying the identifier produces a one-cycle pulse to that source's gateway.

Top module: `irq_claim_core`

## Requirements
- R1: Source identifiers run from 1 to NSRC, and pending bit k of `src_req`/`cmpl_pulse` belongs to source k+1. A claim with no eligible source returns identifier 0. The returned identifier never exceeds NSRC.
- R2: When two eligible sources share the highest priority, the claim returns the smaller identifier.
- R3: Notification bit t is high exactly when some pending source enabled for target t has a priority strictly greater than target t's threshold. The bit is registered: it reflects the state one clock edge after that state changes.
- R4: A claim (`claim_vld` with `claim_tgt`) is answered at the next clock edge. At that edge `claim_rsp_vld` is 1 and `claim_id` holds the highest-priority eligible pending source for that target. The same edge clears that source's pending bit.
- R5: Delivery is multicast, so every target with an eligible source is notified. After one target claims the source, a claim by another target returns 0 unless something else qualifies.
- R6: Targets are evaluated independently, each with its own enable mask and threshold. The same pending source can notify one target and not another.
- R7: A request pulse sets the source's pending bit, and the bit stays set until a claim clears it. Further requests while the bit is set add nothing, so one claim empties it.
- R8: A source with priority 0 never raises a notification and is never returned by a claim.
- R9: If a claim takes a source in the same cycle that a new request for it arrives, the pending bit ends up cleared.
- R10: A completion (`cmpl_vld`, `cmpl_id`) with identifier 1..NSRC gives a one-cycle pulse on bit id-1 of `cmpl_pulse` at the next edge. An identifier of 0 or above NSRC gives no pulse.
- R11: Configuration writes use `cfg_kind` 00 = priority (`cfg_idx` = source id), 01 = enable mask (`cfg_idx` = target, data bit k = source k+1), and 10 = threshold (`cfg_idx` = target). Kind 11 is ignored. After reset every pending bit, priority, enable, threshold, notification and pulse is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | NSRC | Request pulses from gateways, bit k = source k+1 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Register kind: 00 priority, 01 enable, 10 threshold |
| cfg_idx | input | IW | Source id or target number |
| cfg_wdata | input | DW | Write data |
| claim_vld | input | 1 | Claim request |
| claim_tgt | input | TW | Claiming target |
| claim_rsp_vld | output | 1 | Claim answered this cycle |
| claim_id | output | IDW | Claimed source id, 0 = none |
| cmpl_vld | input | 1 | Completion strobe |
| cmpl_id | input | IDW | Completed source id |
| cmpl_pulse | output | NSRC | One-cycle completion pulse per gateway |
| notify | output | NTGT | Registered notification per target |

## Verification
Each result has its own due time, counted from the edge that samples a stimulus:

- A request pulse sets the pending bit at that edge, and the notification follows one edge later.
- A configuration write lands at its edge, and the notification reflects it one edge after that.
- A claim answer, and its pending clear, are due at the edge that samples the claim.
- A completion pulse is due at the edge that samples the completion and lasts exactly one cycle.

The bench drives inputs one time unit after a rising edge. It reads outputs one time unit after the edge at which each result is due. It also checks the notification at the edge before, to confirm the one-cycle lag.

// File: rtl/irq_core_pkg.sv
package irq_core_pkg;
    typedef enum logic [1:0] {
        CFG_PRIO = 2'b00,
        CFG_EN   = 2'b01,
        CFG_THR  = 2'b10,
        CFG_NONE = 2'b11
    } cfg_kind_e;
endpackage

// File: rtl/irq_target_arb.sv
module irq_target_arb #(
    parameter int NSRC   = 8,
    parameter int PRIO_W = 3,
    parameter int IDW    = 4
) (
    input  logic [NSRC-1:0]             pend,
    input  logic [NSRC-1:0]             en,
    input  logic [NSRC-1:0][PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]           thr,
    output logic [IDW-1:0]              best_id,
    output logic                        hit
);
    logic [PRIO_W-1:0] best_p;

    // Ascending scan with strict compare: the threshold seeds the bar, ties keep the lower id.
    always_comb begin
        best_p  = thr;
        best_id = '0;
        for (int k = 0; k < NSRC; k++) begin
            if (pend[k] && en[k] && (prio[k] > best_p)) begin
                best_p  = prio[k];
                best_id = IDW'(k + 1);
            end
        end
        hit = (best_id != '0);
    end
endmodule

// File: rtl/irq_cmpl_decode.sv
module irq_cmpl_decode #(
    parameter int NSRC = 8,
    parameter int IDW  = 4
) (
    input  logic            vld,
    input  logic [IDW-1:0]  id,
    output logic [NSRC-1:0] sel
);
    always_comb begin
        for (int k = 0; k < NSRC; k++) begin
            sel[k] = vld && (id == IDW'(k + 1));
        end
    end
endmodule

// File: rtl/irq_claim_core.sv
module irq_claim_core
    import irq_core_pkg::*;
#(
    parameter int NSRC   = 8,
    parameter int NTGT   = 2,
    parameter int PRIO_W = 3,
    parameter int IDW    = $clog2(NSRC + 1),
    parameter int TW     = (NTGT > 1) ? $clog2(NTGT) : 1,
    parameter int IW     = (IDW > TW) ? IDW : TW,
    parameter int DW     = (NSRC > PRIO_W) ? NSRC : PRIO_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_req,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_kind,
    input  logic [IW-1:0]   cfg_idx,
    input  logic [DW-1:0]   cfg_wdata,
    input  logic            claim_vld,
    input  logic [TW-1:0]   claim_tgt,
    output logic            claim_rsp_vld,
    output logic [IDW-1:0]  claim_id,
    input  logic            cmpl_vld,
    input  logic [IDW-1:0]  cmpl_id,
    output logic [NSRC-1:0] cmpl_pulse,
    output logic [NTGT-1:0] notify
);
    typedef struct packed {
        logic [NSRC-1:0]             pend;
        logic [NSRC-1:0][PRIO_W-1:0] prio;
        logic [NTGT-1:0][NSRC-1:0]   en;
        logic [NTGT-1:0][PRIO_W-1:0] thr;
        logic [NTGT-1:0]             notify;
        logic                        rsp_vld;
        logic [IDW-1:0]              rsp_id;
        logic [NSRC-1:0]             cmpl;
    } core_st_t;

    core_st_t st_d, st_q;

    logic [NTGT-1:0][IDW-1:0] best_id;
    logic [NTGT-1:0]          tgt_hit;
    logic [NSRC-1:0]          cmpl_sel;
    logic                     claim_ok;
    logic [IDW-1:0]           claim_sel_id;
    logic [NSRC-1:0]          claim_clr;

    for (genvar t = 0; t < NTGT; t++) begin : g_arb
        irq_target_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDW(IDW)) u_arb (
            .pend    (st_q.pend),
            .en      (st_q.en[t]),
            .prio    (st_q.prio),
            .thr     (st_q.thr[t]),
            .best_id (best_id[t]),
            .hit     (tgt_hit[t])
        );
    end

    irq_cmpl_decode #(.NSRC(NSRC), .IDW(IDW)) u_cmpl (
        .vld (cmpl_vld),
        .id  (cmpl_id),
        .sel (cmpl_sel)
    );

    always_comb begin
        st_d = st_q;

        claim_ok     = claim_vld && (32'(claim_tgt) < NTGT);
        claim_sel_id = claim_ok ? best_id[claim_tgt] : '0;
        for (int k = 0; k < NSRC; k++) begin
            claim_clr[k] = (claim_sel_id == IDW'(k + 1));
        end

        // Claim wins over a same-cycle request for the same source.
        st_d.pend    = (st_q.pend | src_req) & ~claim_clr;
        st_d.rsp_vld = claim_ok;
        st_d.rsp_id  = claim_sel_id;
        st_d.notify  = tgt_hit;
        st_d.cmpl    = cmpl_sel;

        if (cfg_we) begin
            case (cfg_kind_e'(cfg_kind))
                CFG_PRIO: begin
                    for (int k = 0; k < NSRC; k++) begin
                        if (cfg_idx == IW'(k + 1)) st_d.prio[k] = cfg_wdata[PRIO_W-1:0];
                    end
                end
                CFG_EN: begin
                    for (int t = 0; t < NTGT; t++) begin
                        if (cfg_idx == IW'(t)) st_d.en[t] = cfg_wdata[NSRC-1:0];
                    end
                end
                CFG_THR: begin
                    for (int t = 0; t < NTGT; t++) begin
                        if (cfg_idx == IW'(t)) st_d.thr[t] = cfg_wdata[PRIO_W-1:0];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign claim_rsp_vld = st_q.rsp_vld;
    assign claim_id      = st_q.rsp_id;
    assign cmpl_pulse    = st_q.cmpl;
    assign notify        = st_q.notify;

    // Assertions
    assert_id_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        claim_id <= IDW'(NSRC));

    assert_claim_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_rsp_vld && claim_id != '0) |-> !st_q.pend[claim_id - IDW'(1)]);

    assert_rsp_follows_claim_R4: assert property (@(posedge clk) disable iff (!rst_n)
        claim_rsp_vld |-> $past(claim_vld));

    assert_pend_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(st_q.pend) & ~st_q.pend)) |-> $past(claim_vld));

    assert_cmpl_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmpl_pulse));

    assert_cmpl_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|cmpl_pulse) |-> $past(cmpl_vld));
endmodule

// File: tb/irq_claim_core_bench.sv
module irq_claim_core_bench;
    localparam int NSRC = 8, NTGT = 2, PRIO_W = 3, IDW = 4, TW = 1, IW = 4, DW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_req = '0;
    logic            cfg_we = 1'b0;
    logic [1:0]      cfg_kind = '0;
    logic [IW-1:0]   cfg_idx = '0;
    logic [DW-1:0]   cfg_wdata = '0;
    logic            claim_vld = 1'b0;
    logic [TW-1:0]   claim_tgt = '0;
    logic            claim_rsp_vld;
    logic [IDW-1:0]  claim_id;
    logic            cmpl_vld = 1'b0;
    logic [IDW-1:0]  cmpl_id = '0;
    logic [NSRC-1:0] cmpl_pulse;
    logic [NTGT-1:0] notify;

    always #2.5 clk = ~clk;

    irq_claim_core u_irq_claim_core (
        .clk, .rst_n, .src_req, .cfg_we, .cfg_kind, .cfg_idx, .cfg_wdata,
        .claim_vld, .claim_tgt, .claim_rsp_vld, .claim_id,
        .cmpl_vld, .cmpl_id, .cmpl_pulse, .notify
    );

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // priorities of sources 1..8
    localparam logic [2:0] PRIOS [8] = '{3'd2, 3'd5, 3'd5, 3'd0, 3'd1, 3'd7, 3'd3, 3'd7};

    typedef struct packed {
        logic [7:0] req;
        logic [7:0] en;
        logic [2:0] thr;
        logic [3:0] exp_id;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'h06, 8'hFF, 3'd0, 4'd2},  // R2 tie -> lower id
        '{8'h06, 8'h04, 3'd0, 4'd3},  // R3 enable masks src2
        '{8'h08, 8'hFF, 3'd0, 4'd0},  // R8 prio 0
        '{8'hA0, 8'hFF, 3'd6, 4'd6},  // R2 tie at prio 7
        '{8'hA0, 8'hFF, 3'd7, 4'd0},  // R3 strict compare
        '{8'h13, 8'hFF, 3'd4, 4'd2},  // R3 threshold filters
        '{8'h13, 8'h11, 3'd1, 4'd1},  // R3 mask + threshold
        '{8'h00, 8'hFF, 3'd0, 4'd0}   // R1 nothing pending
    };

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cfg_write(logic [1:0] kind, int idx, int data);
        cfg_we = 1'b1; cfg_kind = kind; cfg_idx = IW'(idx); cfg_wdata = DW'(data);
        cyc();
        cfg_we = 1'b0;
    endtask

    task automatic pulse_req(logic [7:0] mask);
        src_req = mask;
        cyc();
        src_req = '0;
    endtask

    task automatic claim(int tgt, output int id);
        claim_vld = 1'b1; claim_tgt = TW'(tgt);
        cyc();
        claim_vld = 1'b0;
        id = int'(claim_id);
        check(claim_rsp_vld === 1'b1, "R4 rsp_vld", int'(claim_rsp_vld), 1);
    endtask

    task automatic drain();
        int id;
        for (int i = 0; i < 10; i++) begin
            claim(1, id);
            if (id == 0) break;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int id;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R11 reset state
        check(notify == '0, "R11 notify", int'(notify), 0);
        check(cmpl_pulse == '0, "R11 cmpl", int'(cmpl_pulse), 0);
        check(claim_rsp_vld == 1'b0, "R11 rsp_vld", int'(claim_rsp_vld), 0);
        claim(0, id);
        check(id == 0, "R1 claim after reset", id, 0);

        for (int s = 0; s < 8; s++) cfg_write(2'b00, s + 1, PRIOS[s]);
        cfg_write(2'b01, 1, 8'hFF);
        cfg_write(2'b10, 1, 0);

        // Vector table
        foreach (VECS[v]) begin
            cfg_write(2'b01, 0, VECS[v].en);
            cfg_write(2'b10, 0, VECS[v].thr);
            pulse_req(VECS[v].req);
            cyc();
            check(notify[0] == (VECS[v].exp_id != 0), $sformatf("R3 vec%0d notify", v),
                  int'(notify[0]), int'(VECS[v].exp_id != 0));
            claim(0, id);
            check(id == int'(VECS[v].exp_id), $sformatf("R2/R3 vec%0d id", v), id, int'(VECS[v].exp_id));
            drain();
        end

        // R11 kind 11 ignored: would set thr0 to 7 if decoded
        cfg_write(2'b01, 0, 8'hFF);
        cfg_write(2'b10, 0, 0);
        cfg_write(2'b11, 0, 7);
        pulse_req(8'h01);
        cyc();
        check(notify[0] == 1'b1, "R11 kind 11 ignored", int'(notify[0]), 1);
        drain();

        // R3 registered lag and threshold update
        pulse_req(8'h20);
        check(notify[0] == 1'b0, "R3 lag before", int'(notify[0]), 0);
        cyc();
        check(notify[0] == 1'b1, "R3 lag after", int'(notify[0]), 1);
        cfg_write(2'b10, 0, 7);
        check(notify[0] == 1'b1, "R3 thr lag", int'(notify[0]), 1);
        cyc();
        check(notify[0] == 1'b0, "R3 thr strict", int'(notify[0]), 0);
        claim(0, id);
        check(id == 0, "R3 claim blocked", id, 0);
        cfg_write(2'b10, 0, 0);
        claim(0, id);
        check(id == 6, "R3 claim after lowering", id, 6);

        // R5 multicast
        cfg_write(2'b01, 0, 8'h40);
        cfg_write(2'b01, 1, 8'h40);
        pulse_req(8'h40);
        cyc();
        check(notify == 2'b11, "R5 both notified", int'(notify), 3);
        claim(1, id);
        check(id == 7, "R5 first claimer", id, 7);
        claim(0, id);
        check(id == 0, "R5 second claimer", id, 0);
        check(notify == 2'b00, "R5 notify dropped", int'(notify), 0);

        // R6 independent targets
        cfg_write(2'b01, 0, 8'hFF);
        cfg_write(2'b01, 1, 8'hFF);
        cfg_write(2'b10, 0, 2);
        cfg_write(2'b10, 1, 5);
        pulse_req(8'h40);
        cyc();
        check(notify == 2'b01, "R6 per-target notify", int'(notify), 1);
        claim(1, id);
        check(id == 0, "R6 target1 filtered", id, 0);
        claim(0, id);
        check(id == 7, "R6 target0 claims", id, 7);

        // R7 hold and absorbed repeat requests
        cfg_write(2'b10, 0, 0);
        pulse_req(8'h01);
        cyc();
        pulse_req(8'h01);
        repeat (5) cyc();
        check(notify[0] == 1'b1, "R7 held", int'(notify[0]), 1);
        claim(0, id);
        check(id == 1, "R7 claim", id, 1);
        claim(0, id);
        check(id == 0, "R7 single pending", id, 0);

        // R9 claim and request in the same cycle
        pulse_req(8'h40);
        src_req = 8'h40;
        claim(0, id);
        src_req = '0;
        check(id == 7, "R9 claim id", id, 7);
        claim(0, id);
        check(id == 0, "R9 bit cleared", id, 0);
        cyc();
        check(notify[0] == 1'b0, "R9 notify", int'(notify[0]), 0);

        // R10 completion
        cmpl_vld = 1'b1; cmpl_id = 4'd3;
        cyc();
        cmpl_vld = 1'b0;
        check(cmpl_pulse == 8'h04, "R10 pulse", int'(cmpl_pulse), 4);
        cyc();
        check(cmpl_pulse == 8'h00, "R10 one cycle", int'(cmpl_pulse), 0);
        cmpl_vld = 1'b1; cmpl_id = 4'd0;
        cyc();
        check(cmpl_pulse == 8'h00, "R10 id 0", int'(cmpl_pulse), 0);
        cmpl_id = 4'd9;
        cyc();
        check(cmpl_pulse == 8'h00, "R10 id 9", int'(cmpl_pulse), 0);
        cmpl_id = 4'd8;
        cyc();
        cmpl_vld = 1'b0;
        check(cmpl_pulse == 8'h80, "R10 id 8", int'(cmpl_pulse), 128);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule